// File: doc/BRIEF.md
# Start-Stop Time Interval Counter

This block measures a time interval by counting pulses of a time-base enable while an internal gate is set. At a 1 MHz time base, each count is one microsecond, so the result reads directly in microseconds. One gate element is steered three ways, so a single counter serves three measurements. In two-channel mode, an edge on channel A opens the gate and an edge on channel B closes it. In pulse-width mode, the rising and falling edges of channel A open and close it. In period mode, the gate toggles on successive rising edges of channel A, JK style, so it spans exactly one input cycle.

A measurement begins with an arm command. The block then waits for the opening edge, counts while the gate is set, and issues a one-cycle done pulse when the gate closes. The count is then held until the next arm. The inputs are already-digital signals that a front end has squared up. They pass through a parameterised synchroniser before edge detection. A counter that reaches all ones stops there and raises a sticky overflow flag instead of wrapping.

Top module: `interval_counter`

## Requirements
- R1: After reset, count is 0 and done, busy and ovf are all low.
- R2: An arm pulse while busy is low clears count and ovf and raises busy in the next cycle. An arm pulse while busy is high is ignored and does not disturb the measurement in progress.
- R3: In mode 0 (two-channel), the gate opens on a rising edge of sig_a while armed and closes on a rising edge of sig_b. With tb_tick held high, count equals the spacing of the two edges in clock cycles.
- R4: In mode 0, if the rising edges of sig_a and sig_b reach the gate in the same cycle while armed, the close request wins. The gate stays shut, count stays 0, and the block stays armed for a later start.
- R5: In mode 1 (pulse width), the gate spans from a rising edge to the next falling edge of sig_a, and count equals the high time in cycles when tb_tick is high.
- R6: In mode 2 (period), the gate spans from one rising edge of sig_a to the next rising edge of sig_a, and count equals that period in cycles when tb_tick is high.
- R7: count advances by one only in a cycle where the gate is open and tb_tick is high. With tb_tick low, it does not advance.
- R8: Closing the gate produces a done pulse exactly one cycle wide, with busy low. Count is then held constant until the next accepted arm.
- R9: A tick that arrives while count is all ones leaves count at all ones and sets ovf. ovf stays set until the next accepted arm. Reaching all ones without a further tick does not set ovf.
- R10: sig_b has no effect in modes 1 and 2. Edges on either input while not armed do not raise busy or done, and they do not change count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base enable, one pulse per time-base period |
| mode | input | 2 | 0 two-channel, 1 pulse width, 2 period, 3 treated as 0 |
| arm | input | 1 | Start a new measurement (accepted only while idle) |
| sig_a | input | 1 | Start channel / measured signal |
| sig_b | input | 1 | Stop channel for two-channel mode |
| count | output | CNT_W | Ticks counted while the gate was open |
| done | output | 1 | One-cycle pulse when the gate closes |
| busy | output | 1 | Armed or gate open |
| ovf | output | 1 | Sticky saturation flag |

## Verification
In two-channel mode, the start request and the stop request can reach the gate in the same cycle. The bench provokes this by raising sig_a and sig_b on the same clock edge of an armed measurement. It then judges that count is still 0 and busy is still high, so the stop won and the arm survived. A second start and stop then follow at a known spacing, and count must equal exactly that spacing.

// File: rtl/tic_pkg.sv
package tic_pkg;
   typedef enum logic [1:0] {
      TIC_SPAN   = 2'd0,
      TIC_WIDTH  = 2'd1,
      TIC_PERIOD = 2'd2,
      TIC_RSVD   = 2'd3
   } tic_mode_e;
endpackage

// File: rtl/tic_edge.sv
// Synchroniser plus one history flop; edge decoding is left to the caller.
module tic_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic lvl_now,
   output logic lvl_prev
);
   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_now = sig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= sig_in;
               for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign lvl_now = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl_now;
   end
endmodule

// File: rtl/tic_gate.sv
// Gate element: set/clear with clear priority; period mode behaves as a JK toggle.
module tic_gate
   import tic_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arm_req,
   input  tic_mode_e mode,
   input  logic      a_rise,
   input  logic      a_fall,
   input  logic      b_rise,
   output logic      gate,
   output logic      armed,
   output logic      done
);
   logic set_c;
   logic clr_c;
   logic idle;

   assign idle  = !armed && !gate;
   assign set_c = armed && a_rise;

   always_comb begin
      unique case (mode)
         TIC_WIDTH:  clr_c = gate && a_fall;
         TIC_PERIOD: clr_c = gate && a_rise;   // K side of the toggle
         default:    clr_c = b_rise;           // unqualified so it can collide with set
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate  <= 1'b0;
         armed <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (idle && arm_req) begin
            armed <= 1'b1;
         end else if (clr_c) begin
            if (gate) begin
               gate <= 1'b0;
               done <= 1'b1;
            end
         end else if (set_c) begin
            gate  <= 1'b1;
            armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tic_accum.sv
// Saturating tick accumulator with sticky overflow.
module tic_accum #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clear) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (step) begin
         if (count == CNT_MAX) ovf   <= 1'b1;
         else                  count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
   import tic_pkg::*;
#(
   parameter int unsigned CNT_W       = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_tick,
   input  logic [1:0]       mode,
   input  logic             arm,
   input  logic             sig_a,
   input  logic             sig_b,
   output logic [CNT_W-1:0] count,
   output logic             done,
   output logic             busy,
   output logic             ovf
);
   generate
      if (CNT_W < 2 || CNT_W > 48) begin : g_bad_width
         $error("interval_counter: CNT_W must lie in 2..48");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("interval_counter: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic a_now, a_prev, b_now, b_prev;
   logic a_rise, a_fall, b_rise;
   logic gate_open, armed;
   logic accept_arm;

   tic_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_a (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_a), .lvl_now(a_now), .lvl_prev(a_prev)
   );
   tic_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_b (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_b), .lvl_now(b_now), .lvl_prev(b_prev)
   );

   assign a_rise = a_now && !a_prev;
   assign a_fall = !a_now && a_prev;
   assign b_rise = b_now && !b_prev;

   tic_gate u_gate (
      .clk(clk), .rst_n(rst_n), .arm_req(arm), .mode(tic_mode_e'(mode)),
      .a_rise(a_rise), .a_fall(a_fall), .b_rise(b_rise),
      .gate(gate_open), .armed(armed), .done(done)
   );

   assign busy       = armed || gate_open;
   assign accept_arm = arm && !busy;

   tic_accum #(.CNT_W(CNT_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .clear(accept_arm), .step(gate_open && tb_tick),
      .count(count), .ovf(ovf)
   );
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
   parameter int unsigned CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tb_tick,
   input logic             arm,
   input logic             gate_open,
   input logic [CNT_W-1:0] count,
   input logic             done,
   input logic             busy,
   input logic             ovf
);
   p_arm_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm && !busy |=> busy && count == '0 && !ovf);

   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (count == $past(count) || count == $past(count) + 1'b1));

   p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tb_tick && !arm |=> $stable(count));

   p_closed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_open && !arm |=> $stable(count));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !arm |=> ovf);

   p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !arm |=> !busy);
endmodule

bind interval_counter tic_checker #(.CNT_W(CNT_W)) u_tic_chk (
   .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .arm(arm), .gate_open(gate_open),
   .count(count), .done(done), .busy(busy), .ovf(ovf)
);

// File: tb/interval_counter_tb_top.sv
module interval_counter_tb_top;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tb_tick = 1'b1;
   logic [1:0]    mode = 2'd0;
   logic          arm = 1'b0;
   logic          sig_a = 1'b0;
   logic          sig_b = 1'b0;
   logic [CW-1:0] count;
   logic          done, busy, ovf;

   int n_checks = 0;
   int n_fail   = 0;
   int tick_sel = 0;   // 0 always high, 1 always low, 2 alternate
   int cyc      = 0;

   interval_counter #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .mode(mode), .arm(arm),
      .sig_a(sig_a), .sig_b(sig_b), .count(count), .done(done), .busy(busy), .ovf(ovf)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      case (tick_sel)
         0:       tb_tick <= 1'b1;
         1:       tb_tick <= 1'b0;
         default: tb_tick <= ~tb_tick;
      endcase
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_arm(input logic [1:0] m);
      mode = m;
      arm  = 1'b1;
      step(1);
      arm  = 1'b0;
   endtask

   task automatic wait_done(input string req);
      bit got = 0;
      for (int i = 0; i < 3000; i++) begin
         step(1);
         if (done) begin
            got = 1;
            break;
         end
      end
      check(req, got, 1);
   endtask

   task automatic run_span(input int k);
      do_arm(2'd0);
      step(2);
      sig_a = 1'b1;
      step(k);
      sig_b = 1'b1;
      wait_done("R8 done after span");
   endtask

   task automatic settle();
      sig_a = 1'b0;
      sig_b = 1'b0;
      step(5);
   endtask

   task automatic t_reset();
      check("R1 count", count, 0);
      check("R1 done", done, 0);
      check("R1 busy", busy, 0);
      check("R1 ovf", ovf, 0);
   endtask

   task automatic t_span(input int k);
      run_span(k);
      check("R3 span count", count, k);
      step(1);
      check("R8 done one cycle", done, 0);
      check("R8 busy low after close", busy, 0);
      settle();
      check("R8 count held", count, k);
   endtask

   task automatic t_simul();
      do_arm(2'd0);
      step(2);
      sig_a = 1'b1;
      sig_b = 1'b1;
      step(8);
      check("R4 still armed", busy, 1);
      check("R4 no count", count, 0);
      settle();
      sig_a = 1'b1;
      step(6);
      sig_b = 1'b1;
      wait_done("R4 done after later start");
      check("R4 count after later start", count, 6);
      settle();
   endtask

   task automatic t_width();
      do_arm(2'd1);
      step(2);
      sig_a = 1'b1;
      step(3);
      sig_b = 1'b1;   // R10: ignored in width mode
      step(5);
      sig_b = 1'b0;
      step(12);
      sig_a = 1'b0;
      wait_done("R5 done");
      check("R5 width count, R10 sig_b ignored", count, 20);
      settle();
   endtask

   task automatic t_period();
      do_arm(2'd2);
      step(2);
      sig_a = 1'b1;
      step(4);
      sig_b = 1'b1;   // R10: ignored in period mode
      sig_a = 1'b0;
      step(6);
      sig_a = 1'b1;
      wait_done("R6 done");
      check("R6 period count", count, 10);
      step(1);
      sig_a = 1'b0;
      step(3);
      sig_a = 1'b1;
      step(3);
      sig_a = 1'b0;
      step(5);
      check("R10 later edges keep count", count, 10);
      check("R10 later edges keep idle", busy, 0);
      settle();
   endtask

   task automatic t_tick();
      tick_sel = 1;
      run_span(20);
      check("R7 no tick no count", count, 0);
      settle();
      tick_sel = 2;
      run_span(20);
      check("R7 half-rate ticks", count, 10);
      settle();
      tick_sel = 0;
      step(2);
   endtask

   task automatic t_arm_busy();
      do_arm(2'd0);
      step(2);
      sig_a = 1'b1;
      step(5);
      arm = 1'b1;
      step(1);
      arm = 1'b0;
      step(9);
      sig_b = 1'b1;
      wait_done("R2 done");
      check("R2 arm while busy ignored", count, 15);
      settle();
   endtask

   task automatic t_ovf();
      run_span(255);
      check("R9 full scale count", count, 255);
      check("R9 no ovf at full scale", ovf, 0);
      settle();
      run_span(300);
      check("R9 saturated count", count, 255);
      check("R9 ovf set", ovf, 1);
      settle();
      check("R9 ovf sticky", ovf, 1);
      do_arm(2'd0);
      check("R2 arm clears count", count, 0);
      check("R2 arm clears ovf", ovf, 0);
      check("R2 arm raises busy", busy, 1);
      step(2);
      sig_a = 1'b1;
      step(3);
      sig_b = 1'b1;
      wait_done("R2 done after rearm");
      check("R3 short span", count, 3);
      settle();
   endtask

   task automatic t_idle();
      bit saw_busy = 0;
      bit saw_done = 0;
      mode = 2'd0;
      for (int i = 0; i < 24; i++) begin
         sig_a = ~sig_a;
         if (i % 3 == 0) sig_b = ~sig_b;
         step(1);
         if (busy) saw_busy = 1;
         if (done) saw_done = 1;
      end
      settle();
      check("R10 idle edges no busy", saw_busy, 0);
      check("R10 idle edges no done", saw_done, 0);
      check("R10 idle edges keep count", count, 3);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_span(37);
      t_span(1);
      t_simul();
      t_width();
      t_period();
      t_tick();
      t_arm_busy();
      t_ovf();
      t_idle();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule